// File: doc/BRIEF.md
# Registered bidirectional bus transceiver

This block joins two bidirectional 8-bit ports, A and B. Each tri-state port is modelled as three vectors: the value seen on the pins (`*_i`), the value the block would drive (`*_o`) and a per-bit drive enable (`*_oe_o`). An active-low enable and a direction input pick the port that is driven, if any. The two ports are never driven together.

Each direction has its own holding register with its own rising-edge clock. The A-to-B register loads from port A and the B-to-A register loads from port B. A clock edge loads whatever the pins show, whatever the direction and enable inputs are set to. Each direction also has a source select. It chooses whether the driven port shows live data from the opposite port or the contents of that direction's register.

A typical use is to latch a bus value while the port is only listening, then present the stored value later on the other side. Another use is to pass data straight through while a snapshot is kept in the register.

Top module: `bus_xcvr_reg`

## Requirements
- R1: While `rst_ni` is low, both holding registers clear to 0. A stored-source readout after reset shows 8'h00 on either port.
- R2: `a_oe_o` and `b_oe_o` are never both non-zero. When `oe_ni` is high, both are all zeros.
- R3: With `oe_ni` low, `dir_i`=1 makes `b_oe_o` all ones and `a_oe_o` all zeros. `dir_i`=0 makes `a_oe_o` all ones and `b_oe_o` all zeros.
- R4: When port B is driven and `ab_sel_i`=0, `b_o` equals `a_i` in the same cycle. When port A is driven and `ba_sel_i`=0, `a_o` equals `b_i`.
- R5: When port B is driven and `ab_sel_i`=1, `b_o` shows the A-to-B register. When port A is driven and `ba_sel_i`=1, `a_o` shows the B-to-A register.
- R6: A rising edge of `ab_clk_i` loads `a_i` into the A-to-B register, and a rising edge of `ba_clk_i` loads `b_i` into the B-to-A register. Neither load is gated by `dir_i` or `oe_ni`, and neither load disturbs the other register.
- R7: With both ports at high impedance (`oe_ni`=1), both registers still load. The loaded values appear once the matching port is enabled with the stored source selected.
- R8: The data output of a port that is not driven is 8'h00.
- R9: Between its clock edges, a register holds its value. Changes on the source port do not alter the stored readout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Asynchronous active-low clear of both registers |
| ab_clk_i | input | 1 | Load clock of the A-to-B register |
| ba_clk_i | input | 1 | Load clock of the B-to-A register |
| oe_ni | input | 1 | Active-low enable for port drive |
| dir_i | input | 1 | 1: drive port B; 0: drive port A |
| ab_sel_i | input | 1 | Source for port B: 0 live A, 1 stored |
| ba_sel_i | input | 1 | Source for port A: 0 live B, 1 stored |
| a_i | input | 8 | Value present on port A pins |
| a_o | output | 8 | Data driven onto port A |
| a_oe_o | output | 8 | Per-bit drive enable of port A |
| b_i | input | 8 | Value present on port B pins |
| b_o | output | 8 | Data driven onto port B |
| b_oe_o | output | 8 | Per-bit drive enable of port B |

## Verification
A register load can land in the same cycle in which the port fed by that register shows stored data. The stored readout must then step to the new value at once, and the drive enables must stay as they are. The bench provokes this by pulsing one or both register clocks in steps where the stored source is selected and the direction is random. The pulse comes before the sampling point. The behavioural model updates its stored copy on the pulse, so the bench compares the new value on that same clock, and it also confirms that the enables have not moved.

// File: rtl/xcvr_pkg.sv
`timescale 1ns/100ps
package xcvr_pkg;
  typedef enum logic {
    DIR_TO_A = 1'b0,
    DIR_TO_B = 1'b1
  } xfer_dir_e;

  typedef enum logic {
    SRC_LIVE   = 1'b0,
    SRC_STORED = 1'b1
  } src_sel_e;

  localparam int unsigned NUM_DIR = 2;
  localparam int unsigned IDX_AB  = 0;
  localparam int unsigned IDX_BA  = 1;
endpackage

// File: rtl/xcvr_store.sv
`timescale 1ns/100ps
module xcvr_store #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= d_i;
  end

  // R6: every edge loads the pin value, no qualification
  a_r6_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> (q_o == $past(d_i)));
endmodule

// File: rtl/xcvr_src_mux.sv
`timescale 1ns/100ps
module xcvr_src_mux
  import xcvr_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  src_sel_e     sel_i,
  input  logic         en_i,
  input  logic [W-1:0] live_i,
  input  logic [W-1:0] held_i,
  output logic [W-1:0] out_o
);
  logic [W-1:0] pick;

  always_comb begin
    unique case (sel_i)
      SRC_STORED: pick = held_i;
      default:    pick = live_i;
    endcase
  end

  // undriven port data parked at zero
  assign out_o = en_i ? pick : '0;
endmodule

// File: rtl/xcvr_drive_ctl.sv
`timescale 1ns/100ps
module xcvr_drive_ctl
  import xcvr_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         oe_ni,
  input  xfer_dir_e    dir_i,
  output logic         a_en_o,
  output logic         b_en_o,
  output logic [W-1:0] a_oe_o,
  output logic [W-1:0] b_oe_o
);
  always_comb begin
    a_en_o = 1'b0;
    b_en_o = 1'b0;
    if (!oe_ni) begin
      unique case (dir_i)
        DIR_TO_B: b_en_o = 1'b1;
        default:  a_en_o = 1'b1;
      endcase
    end
  end

  assign a_oe_o = {W{a_en_o}};
  assign b_oe_o = {W{b_en_o}};
endmodule

// File: rtl/bus_xcvr_reg.sv
`timescale 1ns/100ps
module bus_xcvr_reg
  import xcvr_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         rst_ni,
  input  logic         ab_clk_i,
  input  logic         ba_clk_i,
  input  logic         oe_ni,
  input  logic         dir_i,
  input  logic         ab_sel_i,
  input  logic         ba_sel_i,
  input  logic [W-1:0] a_i,
  output logic [W-1:0] a_o,
  output logic [W-1:0] a_oe_o,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] b_o,
  output logic [W-1:0] b_oe_o
);
  localparam int unsigned ND = NUM_DIR;

  logic         a_en, b_en;
  logic [ND-1:0]        clk_v, en_v;
  logic [ND-1:0]        sel_v;
  logic [ND-1:0][W-1:0] src_v, held_v, out_v;

  xcvr_drive_ctl #(.W(W)) u_drive (
    .oe_ni  (oe_ni),
    .dir_i  (xfer_dir_e'(dir_i)),
    .a_en_o (a_en),
    .b_en_o (b_en),
    .a_oe_o (a_oe_o),
    .b_oe_o (b_oe_o)
  );

  // index 0: A-to-B path, index 1: B-to-A path
  assign clk_v[IDX_AB] = ab_clk_i;
  assign clk_v[IDX_BA] = ba_clk_i;
  assign src_v[IDX_AB] = a_i;
  assign src_v[IDX_BA] = b_i;
  assign sel_v[IDX_AB] = ab_sel_i;
  assign sel_v[IDX_BA] = ba_sel_i;
  assign en_v[IDX_AB]  = b_en;
  assign en_v[IDX_BA]  = a_en;

  for (genvar g = 0; g < ND; g++) begin : g_path
    xcvr_store #(.W(W)) u_store (
      .clk_i  (clk_v[g]),
      .rst_ni (rst_ni),
      .d_i    (src_v[g]),
      .q_o    (held_v[g])
    );

    xcvr_src_mux #(.W(W)) u_mux (
      .sel_i  (src_sel_e'(sel_v[g])),
      .en_i   (en_v[g]),
      .live_i (src_v[g]),
      .held_i (held_v[g]),
      .out_o  (out_v[g])
    );
  end

  assign b_o = out_v[IDX_AB];
  assign a_o = out_v[IDX_BA];

  // R2: never both ports driven
  a_r2_one_port: assert property (@(posedge ab_clk_i) disable iff (!rst_ni)
    !((|a_oe_o) && (|b_oe_o)));

  // R3: direction picks the driven port
  a_r3_dir_b: assert property (@(posedge ab_clk_i) disable iff (!rst_ni)
    (!oe_ni && dir_i) |-> ((&b_oe_o) && !(|a_oe_o)));

  // R4: live pass-through onto B
  a_r4_live_b: assert property (@(posedge ab_clk_i) disable iff (!rst_ni)
    (!oe_ni && dir_i && !ab_sel_i) |-> (b_o == a_i));

  // R5: stored readout onto A
  a_r5_stored_a: assert property (@(posedge ba_clk_i) disable iff (!rst_ni)
    (!oe_ni && !dir_i && ba_sel_i) |-> (a_o == held_v[IDX_BA]));

  // R8: quiet data when disabled
  a_r8_quiet: assert property (@(posedge ba_clk_i) disable iff (!rst_ni)
    oe_ni |-> ((a_o == '0) && (b_o == '0)));
endmodule

// File: tb/bus_xcvr_reg_bench.sv
`timescale 1ns/100ps
module bus_xcvr_reg_bench;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_ni, ab_clk_i, ba_clk_i, oe_ni, dir_i, ab_sel_i, ba_sel_i;
  logic [W-1:0] a_i, b_i, a_o, b_o, a_oe_o, b_oe_o;

  logic [W-1:0] ab_m, ba_m;
  int n_chk = 0, n_fail = 0;
  bit run = 0, done = 0;

  always #2.5 clk = ~clk;

  bus_xcvr_reg #(.W(W)) u_bus_xcvr_reg (
    .rst_ni, .ab_clk_i, .ba_clk_i, .oe_ni, .dir_i, .ab_sel_i, .ba_sel_i,
    .a_i, .a_o, .a_oe_o, .b_i, .b_o, .b_oe_o
  );

  task automatic chk(input bit ok, input string tag, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model compared on every clock
  always @(posedge clk) begin
    if (run) begin
      bit en_a, en_b;
      logic [W-1:0] ea, eb;
      en_b = !oe_ni && dir_i;
      en_a = !oe_ni && !dir_i;
      eb = !en_b ? '0 : (ab_sel_i ? ab_m : a_i);
      ea = !en_a ? '0 : (ba_sel_i ? ba_m : b_i);
      chk(!((|a_oe_o) && (|b_oe_o)), "R2 both driven", a_oe_o, '0);
      chk(b_oe_o === {W{en_b}}, "R3 b_oe", b_oe_o, {W{en_b}});
      chk(a_oe_o === {W{en_a}}, "R3 a_oe", a_oe_o, {W{en_a}});
      chk(b_o === eb, !en_b ? "R8 b_o" : (ab_sel_i ? "R5 b_o" : "R4 b_o"), b_o, eb);
      chk(a_o === ea, !en_a ? "R8 a_o" : (ba_sel_i ? "R5 a_o" : "R4 a_o"), a_o, ea);
    end
  end

  task automatic step(input logic oe_n, input logic dir, input logic abs,
                      input logic bas, input logic [W-1:0] a, input logic [W-1:0] b,
                      input logic pab, input logic pba);
    @(negedge clk);
    oe_ni = oe_n; dir_i = dir; ab_sel_i = abs; ba_sel_i = bas; a_i = a; b_i = b;
    #1;
    if (pab) begin ab_clk_i = 1'b1; ab_m = a; end
    if (pba) begin ba_clk_i = 1'b1; ba_m = b; end
    #0.5;
    ab_clk_i = 1'b0; ba_clk_i = 1'b0;
    @(posedge clk);
    #1;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=running exp=finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b1; ab_clk_i = 1'b0; ba_clk_i = 1'b0; oe_ni = 1'b1; dir_i = 1'b0;
    ab_sel_i = 1'b0; ba_sel_i = 1'b0; a_i = '0; b_i = '0;
    ab_m = '0; ba_m = '0;
    #1 rst_ni = 1'b0;
    repeat (3) @(posedge clk);
    run = 1;
    #1 rst_ni = 1'b1;

    // R1: reset state via stored readout
    step(0, 1, 1, 1, 8'hEE, 8'hDD, 0, 0);
    chk(b_o === 8'h00, "R1 ab reg after reset", b_o, 8'h00);
    step(0, 0, 1, 1, 8'hEE, 8'hDD, 0, 0);
    chk(a_o === 8'h00, "R1 ba reg after reset", a_o, 8'h00);

    // R7: both ports high-Z, load both, then read out
    step(1, 0, 1, 1, 8'hA5, 8'h3C, 1, 1);
    chk(a_o === 8'h00 && b_o === 8'h00, "R8 disabled data", a_o | b_o, 8'h00);
    step(0, 1, 1, 0, 8'h00, 8'h00, 0, 0);
    chk(b_o === 8'hA5, "R7 ab loaded while high-Z", b_o, 8'hA5);
    step(0, 0, 0, 1, 8'h00, 8'hFF, 0, 0);
    chk(a_o === 8'h3C, "R7 ba loaded while high-Z", a_o, 8'h3C);

    // R6: load not gated; other register untouched
    step(0, 1, 0, 0, 8'h5A, 8'h11, 1, 0);
    step(0, 0, 0, 1, 8'h22, 8'h33, 0, 0);
    chk(a_o === 8'h3C, "R6 ba untouched by ab load", a_o, 8'h3C);
    step(0, 1, 1, 0, 8'h44, 8'h55, 0, 0);
    chk(b_o === 8'h5A, "R6 ab loaded while B driven", b_o, 8'h5A);
    step(0, 1, 1, 0, 8'h66, 8'h81, 0, 1);
    step(0, 0, 0, 1, 8'h77, 8'h99, 0, 0);
    chk(a_o === 8'h81, "R6 ba loaded from driven port", a_o, 8'h81);

    // R9: hold between edges
    step(0, 1, 1, 0, 8'hC3, 8'h00, 0, 0);
    chk(b_o === 8'h5A, "R9 ab holds", b_o, 8'h5A);
    step(0, 0, 0, 1, 8'h00, 8'hC3, 0, 0);
    chk(a_o === 8'h81, "R9 ba holds", a_o, 8'h81);

    // R4: live path
    step(0, 1, 0, 1, 8'h96, 8'h00, 0, 0);
    chk(b_o === 8'h96, "R4 live A to B", b_o, 8'h96);
    step(0, 0, 1, 0, 8'h00, 8'h69, 0, 0);
    chk(a_o === 8'h69, "R4 live B to A", a_o, 8'h69);

    // R5: load and stored readout in the same step
    step(0, 1, 1, 1, 8'hB7, 8'h00, 1, 0);
    chk(b_o === 8'hB7, "R5 same-cycle load and readout", b_o, 8'hB7);

    // random mix, model compared each clock
    for (int i = 0; i < 600; i++) begin
      step($urandom_range(0, 3) == 0, $urandom_range(0, 1), $urandom_range(0, 1),
           $urandom_range(0, 1), W'($urandom), W'($urandom),
           $urandom_range(0, 2) == 0, $urandom_range(0, 2) == 0);
    end

    done = 1;
    summary();
    $finish;
  end
endmodule